// File: doc/BRIEF.md
# Raw NAND Command Sequencer

This block runs the command and address phase of one operation on an 8-bit raw NAND flash bus that serves a single chip. The host presents a one-clock request with an opcode, an optional column address and an optional page (row) address. An internal format table maps the opcode to the number of address bytes it needs and to an optional confirming second command. The block then strobes the first command byte, the address bytes and, when the table defines one, the second command byte. Each byte is a bus cycle with CLE or ALE raised and a WE# low pulse of programmable length. After the last byte it waits for the ready/busy pin, with a programmable timeout. Then it pulses `done`.

Chip enable is managed across multi-step operations. Before most operations CE# goes high for a moment and then low again. The program-confirm, cached-program and erase-confirm opcodes continue the transaction opened by their setup opcode, so CE# stays low for them. When a program, erase or reset finishes, CE# goes high. After any other opcode CE# stays low so that a data phase can follow. A spare-area read request is rewritten as a normal page read whose column is moved past the page data area. Data-phase transfers, ECC and selection between several chips are handled elsewhere.

Top module: `nand_cmd_seq`

## Requirements
- R1: The format table sets address byte counts and second commands: 0x00 takes 5 bytes then 0x30, and 0x05 takes 2 bytes then 0xE0. The opcodes 0x90, 0xEC, 0xEE and 0xEF take 1 byte and 0x70 takes none. 0x80 takes 5 bytes, 0x85 takes 2 and 0x60 takes 3. 0x10, 0x15, 0xD0 and 0xFF take none. Only 0x00 and 0x05 issue a second command.
- R2: An opcode that is not in the table is sent as one command cycle, with no address cycles and no second command.
- R3: When a column is supplied, the address bytes go out in this order: column bits 7:0, column bits 15:8, page bits 7:0, page bits 15:8, page bits 23:16. A page that is not supplied sends zero bytes in those slots.
- R4: When only a page is supplied, page bits 7:0, 15:8 and 23:16 fill the first three address slots and any later slots carry zero. When neither is supplied, all address bytes are zero.
- R5: Opcode 0x50 (spare-area read) is sent exactly like opcode 0x00 with a column present. The column is the requested column plus PAGE_BYTES (2048 by default), modulo 2^16.
- R6: For every opcode except 0x10, 0x15 and 0xD0, CE# is high for at least one clock after the request and before the first WE# pulse. For those three opcodes, a CE# that is low at the time of the request stays low. CE# is low whenever CLE or ALE is high.
- R7: When an operation with opcode 0x10, 0x15, 0xD0 or 0xFF completes, CE# is high afterwards. After any other opcode completes, CE# stays low.
- R8: CLE is high only during command cycles and ALE only during address cycles, never both at once. WE# goes low only inside such a cycle, for max(cfg_we_low,1) clocks. nand_dq_out carries the cycle's byte when WE# rises.
- R9: `done` pulses for one clock only after nand_rb_n has been sampled high following the last bus cycle. `busy` is high from acceptance of the request until `done`.
- R10: If nand_rb_n stays low for more than cfg_rdy_tmo clocks after the last bus cycle, `done` pulses with `tmo_err` high and CE# is driven high.
- R11: After reset, CE# and WE# are high, CLE and ALE are low, and `busy`, `done` and `tmo_err` are low.
- R12: A request presented while `busy` is high is ignored: it produces no bus cycle at any time.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | One-clock request strobe, taken only when idle |
| req_op | input | 8 | Opcode |
| req_col_vld | input | 1 | Column address present |
| req_col | input | 16 | Column address |
| req_page_vld | input | 1 | Page address present |
| req_page | input | 24 | Page address |
| cfg_we_low | input | 4 | WE# low time in clocks (0 is treated as 1) |
| cfg_rdy_tmo | input | 16 | Ready-wait limit in clocks |
| nand_rb_n | input | 1 | Ready/busy from the flash, high means ready (synchronous to clk) |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write enable, active low, latched on its rising edge |
| nand_dq_out | output | 8 | Byte driven onto the flash data bus |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock completion pulse |
| tmo_err | output | 1 | High with `done` when the ready wait timed out |

## Verification
The hardest conditions to reach are the ones that depend on history. Whether CE# stays low for a confirm opcode depends on the opcode before it. The ready wait behaves differently when the flash reports busy after the last strobe than when it is already ready. The bench chains setup and confirm requests back to back and checks the level of CE# going into each one. It holds nand_rb_n low across whole sequences, both to show that `done` waits and to reach the timeout. Random request streams mix table opcodes, unknown codes, the spare-area read and every combination of missing column and page, so CE# reaches each request in both states.

// File: rtl/nand_seq_pkg.sv
// Package: opcode constants, format record and state encodings shared by
// the raw NAND command sequencer. Assumes 8-bit opcodes on the flash bus.
package nand_seq_pkg;

    localparam logic [7:0] OPC_PAGE_RD    = 8'h00;
    localparam logic [7:0] OPC_RD_START   = 8'h30;
    localparam logic [7:0] OPC_COL_RD     = 8'h05;
    localparam logic [7:0] OPC_COL_RD_GO  = 8'hE0;
    localparam logic [7:0] OPC_ID         = 8'h90;
    localparam logic [7:0] OPC_STATUS     = 8'h70;
    localparam logic [7:0] OPC_PROG_SETUP = 8'h80;
    localparam logic [7:0] OPC_PROG_GO    = 8'h10;
    localparam logic [7:0] OPC_PROG_CACHE = 8'h15;
    localparam logic [7:0] OPC_COL_WR     = 8'h85;
    localparam logic [7:0] OPC_ERASE_SET  = 8'h60;
    localparam logic [7:0] OPC_ERASE_GO   = 8'hD0;
    localparam logic [7:0] OPC_RESET      = 8'hFF;
    localparam logic [7:0] OPC_PARAM      = 8'hEC;
    localparam logic [7:0] OPC_FEAT_GET   = 8'hEE;
    localparam logic [7:0] OPC_FEAT_SET   = 8'hEF;
    localparam logic [7:0] OPC_SPARE_RD   = 8'h50;

    // Per-opcode sequence description
    typedef struct packed {
        logic [2:0] n_addr;
        logic       has_cmd2;
        logic [7:0] cmd2;
        logic       hold_ce;   // continue the transaction of the previous op
        logic       end_ce;    // release CE# once complete
    } op_fmt_t;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_PREP, SQ_GAP, SQ_CYC, SQ_WAIT, SQ_FIN
    } seq_st_t;

    typedef enum logic [1:0] {
        BC_IDLE, BC_SETUP, BC_LOW, BC_HOLD
    } bus_st_t;

endpackage

// File: rtl/nand_fmt_table.sv
// Module: opcode format lookup. Pure combinational decode of an opcode to its
// address byte count, optional second command and chip-enable policy.
// Assumes a spare-area read has already been rewritten to a page read.
module nand_fmt_table
    import nand_seq_pkg::*;
(
    input  logic [7:0] op,
    output op_fmt_t    fmt
);

    // Table decode; unknown opcodes get a bare single command cycle
    always_comb begin
        fmt = '{n_addr: 3'd0, has_cmd2: 1'b0, cmd2: 8'h00, hold_ce: 1'b0, end_ce: 1'b0};
        case (op)
            OPC_PAGE_RD:    begin fmt.n_addr = 3'd5; fmt.has_cmd2 = 1'b1; fmt.cmd2 = OPC_RD_START; end
            OPC_COL_RD:     begin fmt.n_addr = 3'd2; fmt.has_cmd2 = 1'b1; fmt.cmd2 = OPC_COL_RD_GO; end
            OPC_ID,
            OPC_PARAM,
            OPC_FEAT_GET,
            OPC_FEAT_SET:   fmt.n_addr = 3'd1;
            OPC_PROG_SETUP: fmt.n_addr = 3'd5;
            OPC_COL_WR:     fmt.n_addr = 3'd2;
            OPC_ERASE_SET:  fmt.n_addr = 3'd3;
            OPC_PROG_GO,
            OPC_PROG_CACHE,
            OPC_ERASE_GO:   begin fmt.hold_ce = 1'b1; fmt.end_ce = 1'b1; end
            OPC_RESET:      fmt.end_ce = 1'b1;
            default:        ;
        endcase
    end

endmodule

// File: rtl/nand_addr_builder.sv
// Module: forms the address byte list from optional column and page fields.
// With a column the column bytes lead and the page bytes follow; without one
// the page bytes start at slot 0. A spare-area flag shifts the column by the
// page data size and forces the column to be present.
module nand_addr_builder #(
    parameter int COL_BYTES  = 2,
    parameter int ROW_BYTES  = 3,
    parameter int PAGE_BYTES = 2048,
    localparam int SLOTS     = COL_BYTES + ROW_BYTES
) (
    input  logic                   spare,
    input  logic                   col_vld,
    input  logic [8*COL_BYTES-1:0] col,
    input  logic                   page_vld,
    input  logic [8*ROW_BYTES-1:0] page,
    output logic [8*SLOTS-1:0]     bytes_o
);

    localparam logic [8*COL_BYTES-1:0] SPARE_OFS = (8*COL_BYTES)'(PAGE_BYTES);

    logic [8*COL_BYTES-1:0] col_eff;
    logic                   col_use;

    // Effective column after the spare-area shift
    always_comb begin
        col_eff = spare ? col + SPARE_OFS : col;
        col_use = col_vld | spare;
    end

    for (genvar gi = 0; gi < SLOTS; gi++) begin : g_slot
        logic [7:0] with_col;
        logic [7:0] no_col;
        if (gi < COL_BYTES) begin : g_colbyte
            assign with_col = col_eff[8*gi +: 8];
        end else begin : g_rowbyte
            assign with_col = page_vld ? page[8*(gi-COL_BYTES) +: 8] : 8'h00;
        end
        if (gi < ROW_BYTES) begin : g_rowfirst
            assign no_col = page_vld ? page[8*gi +: 8] : 8'h00;
        end else begin : g_zero
            assign no_col = 8'h00;
        end
        assign bytes_o[8*gi +: 8] = col_use ? with_col : no_col;
    end

endmodule

// File: rtl/nand_bus_cycler.sv
// Module: steps through n_slots latch cycles on the flash bus. Each cycle is
// one setup clock with WE# high, max(we_low,1) clocks with WE# low and one
// hold clock with WE# high. The caller drives CLE/ALE/data from slot while
// active is high. Assumes we_low is stable while a sequence runs.
module nand_bus_cycler
    import nand_seq_pkg::*;
#(
    parameter int SLOT_W = 3,
    parameter int WE_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [SLOT_W-1:0] n_slots,
    input  logic [WE_W-1:0]   we_low,
    output logic [SLOT_W-1:0] slot,
    output logic              active,
    output logic              we_n,
    output logic              fin
);

    bus_st_t           st;
    logic [WE_W-1:0]   lo_cnt;
    logic [WE_W-1:0]   lo_tgt;
    logic              last;

    // Low-time target and end-of-sequence decode
    always_comb begin
        lo_tgt = (we_low == '0) ? WE_W'(1) : we_low;
        last   = (slot == n_slots - SLOT_W'(1));
        active = (st != BC_IDLE);
        we_n   = (st != BC_LOW);
        fin    = (st == BC_HOLD) && last;
    end

    // Cycle phase sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= BC_IDLE;
            slot   <= '0;
            lo_cnt <= '0;
        end else begin
            case (st)
                BC_IDLE: if (start) begin
                    slot <= '0;
                    st   <= BC_SETUP;
                end
                BC_SETUP: begin
                    lo_cnt <= WE_W'(1);
                    st     <= BC_LOW;
                end
                BC_LOW: begin
                    if (lo_cnt >= lo_tgt) st <= BC_HOLD;
                    else lo_cnt <= lo_cnt + WE_W'(1);
                end
                BC_HOLD: begin
                    if (last) st <= BC_IDLE;
                    else begin
                        slot <= slot + SLOT_W'(1);
                        st   <= BC_SETUP;
                    end
                end
                default: st <= BC_IDLE;
            endcase
        end
    end

    AST_SLOT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (slot < n_slots)) else $error("slot past sequence end"); // R1

endmodule

// File: rtl/nand_cmd_seq.sv
// Module: raw NAND command/address sequencer for one chip. Accepts one
// request when idle, looks up its format, manages CE#, strobes the command,
// address and optional second command bytes, then waits for ready with a
// timeout. Assumes nand_rb_n is already synchronous to clk and that the cfg_*
// inputs are stable while busy.
module nand_cmd_seq
    import nand_seq_pkg::*;
#(
    parameter int COL_BYTES  = 2,
    parameter int ROW_BYTES  = 3,
    parameter int PAGE_BYTES = 2048,
    parameter int WE_W       = 4,
    parameter int TMO_W      = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [7:0]             req_op,
    input  logic                   req_col_vld,
    input  logic [8*COL_BYTES-1:0] req_col,
    input  logic                   req_page_vld,
    input  logic [8*ROW_BYTES-1:0] req_page,
    input  logic [WE_W-1:0]        cfg_we_low,
    input  logic [TMO_W-1:0]       cfg_rdy_tmo,
    input  logic                   nand_rb_n,
    output logic                   nand_ce_n,
    output logic                   nand_cle,
    output logic                   nand_ale,
    output logic                   nand_we_n,
    output logic [7:0]             nand_dq_out,
    output logic                   busy,
    output logic                   done,
    output logic                   tmo_err
);

    localparam int ADDR_SLOTS = COL_BYTES + ROW_BYTES;
    localparam int MAX_SLOTS  = ADDR_SLOTS + 2;
    localparam int SLOT_W     = $clog2(MAX_SLOTS + 1);

    seq_st_t                 st;
    logic [7:0]              op_q;
    logic                    spare_q;
    logic                    colv_q;
    logic                    pagev_q;
    logic [8*COL_BYTES-1:0]  col_q;
    logic [8*ROW_BYTES-1:0]  page_q;
    logic                    err_q;
    logic [TMO_W-1:0]        tmo_cnt;

    op_fmt_t                 fmt;
    logic [8*ADDR_SLOTS-1:0] abytes;
    logic [SLOT_W-1:0]       n_slots;
    logic [SLOT_W-1:0]       slot;
    logic                    cyc_active;
    logic                    cyc_fin;
    logic                    cyc_start;
    logic                    is_cmd;
    logic [7:0]              slot_byte;
    logic [7:0]              addr_byte;

    nand_fmt_table u_fmt (
        .op  (op_q),
        .fmt (fmt)
    );

    nand_addr_builder #(
        .COL_BYTES  (COL_BYTES),
        .ROW_BYTES  (ROW_BYTES),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_addr (
        .spare    (spare_q),
        .col_vld  (colv_q),
        .col      (col_q),
        .page_vld (pagev_q),
        .page     (page_q),
        .bytes_o  (abytes)
    );

    nand_bus_cycler #(
        .SLOT_W (SLOT_W),
        .WE_W   (WE_W)
    ) u_cyc (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (cyc_start),
        .n_slots (n_slots),
        .we_low  (cfg_we_low),
        .slot    (slot),
        .active  (cyc_active),
        .we_n    (nand_we_n),
        .fin     (cyc_fin)
    );

    // Slot count and sequencer start strobe
    always_comb begin
        n_slots   = SLOT_W'(1) + SLOT_W'(fmt.n_addr) + SLOT_W'(fmt.has_cmd2);
        cyc_start = (st == SQ_GAP) || ((st == SQ_PREP) && fmt.hold_ce);
    end

    // Pick the address byte for the current slot
    always_comb begin
        addr_byte = 8'h00;
        for (int i = 0; i < ADDR_SLOTS; i++) begin
            if (slot == SLOT_W'(i + 1)) addr_byte = abytes[8*i +: 8];
        end
    end

    // Classify the current slot and choose its byte
    always_comb begin
        if (slot == '0) begin
            is_cmd    = 1'b1;
            slot_byte = op_q;
        end else if (slot <= SLOT_W'(fmt.n_addr)) begin
            is_cmd    = 1'b0;
            slot_byte = addr_byte;
        end else begin
            is_cmd    = 1'b1;
            slot_byte = fmt.cmd2;
        end
    end

    // Bus outputs and handshake
    always_comb begin
        nand_cle    = cyc_active && is_cmd;
        nand_ale    = cyc_active && !is_cmd;
        nand_dq_out = cyc_active ? slot_byte : 8'h00;
        busy        = (st != SQ_IDLE);
        done        = (st == SQ_FIN);
        tmo_err     = (st == SQ_FIN) && err_q;
    end

    // Request capture with spare-area rewrite
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= 8'h00;
            spare_q <= 1'b0;
            colv_q  <= 1'b0;
            pagev_q <= 1'b0;
            col_q   <= '0;
            page_q  <= '0;
        end else if ((st == SQ_IDLE) && req_valid) begin
            op_q    <= (req_op == OPC_SPARE_RD) ? OPC_PAGE_RD : req_op;
            spare_q <= (req_op == OPC_SPARE_RD);
            colv_q  <= req_col_vld;
            pagev_q <= req_page_vld;
            col_q   <= req_col;
            page_q  <= req_page;
        end
    end

    // Operation sequencing, chip enable and ready timeout
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= SQ_IDLE;
            nand_ce_n <= 1'b1;
            err_q     <= 1'b0;
            tmo_cnt   <= '0;
        end else begin
            case (st)
                SQ_IDLE: if (req_valid) st <= SQ_PREP;
                SQ_PREP: begin
                    err_q <= 1'b0;
                    if (fmt.hold_ce) begin
                        nand_ce_n <= 1'b0;
                        st        <= SQ_CYC;
                    end else begin
                        nand_ce_n <= 1'b1;
                        st        <= SQ_GAP;
                    end
                end
                SQ_GAP: begin
                    nand_ce_n <= 1'b0;
                    st        <= SQ_CYC;
                end
                SQ_CYC: if (cyc_fin) begin
                    tmo_cnt <= '0;
                    st      <= SQ_WAIT;
                end
                SQ_WAIT: begin
                    if (nand_rb_n) begin
                        nand_ce_n <= fmt.end_ce;
                        st        <= SQ_FIN;
                    end else if (tmo_cnt == cfg_rdy_tmo) begin
                        nand_ce_n <= 1'b1;
                        err_q     <= 1'b1;
                        st        <= SQ_FIN;
                    end else begin
                        tmo_cnt <= tmo_cnt + TMO_W'(1);
                    end
                end
                SQ_FIN: st <= SQ_IDLE;
                default: st <= SQ_IDLE;
            endcase
        end
    end

    AST_CLE_ALE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale)) else $error("CLE and ALE together"); // R8
    AST_WE_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_we_n |-> (nand_cle || nand_ale)) else $error("WE# low outside a cycle"); // R8
    AST_CE_DURING_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (nand_cle || nand_ale) |-> !nand_ce_n) else $error("cycle with CE# high"); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done longer than one clock"); // R9
    AST_DONE_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !tmo_err) |-> $past(nand_rb_n)) else $error("done without ready"); // R9
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_err |-> done) else $error("timeout flag without done"); // R10
    AST_ERR_DROPS_CE: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_err |-> nand_ce_n) else $error("CE# low after timeout"); // R10

endmodule

// File: tb/tb_nand_cmd_seq.sv
`timescale 1ns/1ps
module tb_nand_cmd_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_op = 8'h00;
    logic        req_col_vld = 1'b0;
    logic [15:0] req_col = 16'h0;
    logic        req_page_vld = 1'b0;
    logic [23:0] req_page = 24'h0;
    logic [3:0]  cfg_we_low = 4'd2;
    logic [15:0] cfg_rdy_tmo = 16'd1000;
    logic        nand_rb_n = 1'b1;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n;
    logic [7:0]  nand_dq_out;
    logic        busy, done, tmo_err;

    nand_cmd_seq dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_col_vld(req_col_vld), .req_col(req_col), .req_page_vld(req_page_vld),
        .req_page(req_page), .cfg_we_low(cfg_we_low), .cfg_rdy_tmo(cfg_rdy_tmo),
        .nand_rb_n(nand_rb_n), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
        .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_dq_out(nand_dq_out),
        .busy(busy), .done(done), .tmo_err(tmo_err)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // bus monitor state
    int       ncap;
    int       cap_kind [16];   // 1 command, 2 address, 0 neither
    int       cap_byte [16];
    int       cap_ce   [16];
    int       cap_low  [16];
    int       low_run;
    int       ndone;
    int       done_cyc;
    int       done_err;
    int       last_rise;
    int       ce_went_high;
    logic     prev_we = 1'b1;

    always @(posedge clk) cyc <= cyc + 1;

    // Observe the bus away from the active edge
    always @(negedge clk) begin
        if (!nand_we_n) low_run++;
        if (!prev_we && nand_we_n && ncap < 16) begin
            cap_kind[ncap] = nand_cle ? 1 : (nand_ale ? 2 : 0);
            cap_byte[ncap] = nand_dq_out;
            cap_ce[ncap]   = nand_ce_n;
            cap_low[ncap]  = low_run;
            ncap++;
            last_rise = cyc;
        end
        if (nand_we_n) low_run = 0;
        prev_we = nand_we_n;
        if (ncap == 0 && nand_ce_n) ce_went_high = 1;
        if (done) begin
            ndone++;
            done_cyc = cyc;
            done_err = tmo_err;
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int exp_naddr(input logic [7:0] op);
        case (op)
            8'h00, 8'h80: return 5;
            8'h05, 8'h85: return 2;
            8'h60: return 3;
            8'h90, 8'hEC, 8'hEE, 8'hEF: return 1;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_cmd2(input logic [7:0] op);
        if (op == 8'h00) return 'h30;
        if (op == 8'h05) return 'hE0;
        return -1;
    endfunction

    function automatic bit is_hold(input logic [7:0] op);
        return op == 8'h10 || op == 8'h15 || op == 8'hD0;
    endfunction

    function automatic bit is_end(input logic [7:0] op);
        return is_hold(op) || op == 8'hFF;
    endfunction

    function automatic int exp_addr(input int i, input bit cv, input logic [15:0] c,
                                    input bit pv, input logic [23:0] p);
        logic [23:0] pp;
        pp = pv ? p : 24'h0;
        if (cv) begin
            case (i)
                0: return c[7:0];
                1: return c[15:8];
                2: return pp[7:0];
                3: return pp[15:8];
                default: return pp[23:16];
            endcase
        end
        case (i)
            0: return pp[7:0];
            1: return pp[15:8];
            2: return pp[23:16];
            default: return 0;
        endcase
    endfunction

    task automatic issue(input logic [7:0] op, input bit cv, input logic [15:0] c,
                         input bit pv, input logic [23:0] p);
        @(negedge clk);
        ncap = 0; ndone = 0; ce_went_high = 0; low_run = 0;
        req_valid = 1'b1; req_op = op; req_col_vld = cv; req_col = c;
        req_page_vld = pv; req_page = p;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done(input int limit);
        int t0;
        t0 = cyc;
        while (ndone == 0 && (cyc - t0) < limit) @(negedge clk);
    endtask

    // Compare the captured bus cycles with the expected sequence
    task automatic check_seq(input string tag, input logic [7:0] op, input bit cv,
                             input logic [15:0] c, input bit pv, input logic [23:0] p,
                             input int wl);
        logic [7:0]  eop;
        logic [15:0] ec;
        bit          ecv;
        int          na, c2, n;
        eop = op; ec = c; ecv = cv;
        if (op == 8'h50) begin
            eop = 8'h00; ec = c + 16'd2048; ecv = 1;   // R5
        end
        na = exp_naddr(eop);
        c2 = exp_cmd2(eop);
        n  = 1 + na + (c2 >= 0 ? 1 : 0);
        chk("R1", "cycle count", ncap, n);
        if (ncap == n) begin
            chk(tag, "first command byte", cap_byte[0], eop);
            chk("R8", "first cycle CLE", cap_kind[0], 1);
            for (int i = 0; i < na; i++) begin
                chk(tag, "address byte", cap_byte[1+i], exp_addr(i, ecv, ec, pv, p));
                chk("R8", "address cycle ALE", cap_kind[1+i], 2);
            end
            if (c2 >= 0) begin
                chk("R1", "second command", cap_byte[n-1], c2);
                chk("R8", "second cycle CLE", cap_kind[n-1], 1);
            end
            for (int i = 0; i < n; i++) begin
                chk("R8", "WE# low clocks", cap_low[i], (wl == 0) ? 1 : wl);
                chk("R6", "CE# low in cycle", cap_ce[i], 0);
            end
        end
    endtask

    task automatic full_op(input string tag, input logic [7:0] op, input bit cv,
                           input logic [15:0] c, input bit pv, input logic [23:0] p);
        logic [7:0] eop;
        int ce_before;
        eop = (op == 8'h50) ? 8'h00 : op;
        ce_before = nand_ce_n;
        issue(op, cv, c, pv, p);
        wait_done(3000);
        chk("R9", "done seen", ndone, 1);
        chk("R10", "no timeout", done_err, 0);
        check_seq(tag, op, cv, c, pv, p, cfg_we_low);
        if (!is_hold(eop)) chk("R6", "CE# gap before op", ce_went_high, 1);
        else if (ce_before == 0) chk("R6", "CE# held for confirm", ce_went_high, 0);
        @(negedge clk);
        chk("R7", "CE# after completion", nand_ce_n, is_end(eop) ? 1 : 0);
        chk("R9", "idle after done", busy, 0);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] ops [16];
        int seed;
        ops = '{8'h00, 8'h05, 8'h90, 8'h70, 8'h80, 8'h10, 8'h15, 8'h85,
                8'h60, 8'hD0, 8'hFF, 8'hEC, 8'hEE, 8'hEF, 8'h50, 8'h00};
        seed = $urandom(32'd7139);
        ncap = 0; ndone = 0; low_run = 0; ce_went_high = 0; last_rise = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11", "CE# after reset", nand_ce_n, 1);
        chk("R11", "WE# after reset", nand_we_n, 1);
        chk("R11", "CLE/ALE after reset", {nand_cle, nand_ale}, 0);
        chk("R11", "busy/done/err after reset", {busy, done, tmo_err}, 0);

        // directed sequences
        full_op("R3", 8'h00, 1, 16'h1234, 1, 24'hABCDEF);
        full_op("R4", 8'h60, 0, 16'h0, 1, 24'h0A0B0C);
        full_op("R6", 8'hD0, 0, 16'h0, 0, 24'h0);          // erase confirm keeps CE#
        full_op("R5", 8'h50, 1, 16'h0010, 1, 24'h000102);
        full_op("R5", 8'h50, 1, 16'hF900, 0, 24'h0);        // column wraps
        full_op("R2", 8'hA5, 1, 16'h5555, 1, 24'h666666);
        full_op("R3", 8'h80, 1, 16'h0203, 0, 24'h0);        // page absent -> zeros
        full_op("R6", 8'h10, 0, 16'h0, 0, 24'h0);          // program confirm
        full_op("R7", 8'hFF, 0, 16'h0, 0, 24'h0);
        full_op("R4", 8'h70, 0, 16'h0, 0, 24'h0);
        full_op("R4", 8'h90, 0, 16'h0, 0, 24'h0);          // no address given -> zero byte
        cfg_we_low = 4'd0;
        full_op("R8", 8'h05, 1, 16'h00FE, 0, 24'h0);
        cfg_we_low = 4'd5;
        full_op("R8", 8'hEF, 1, 16'h0077, 0, 24'h0);
        cfg_we_low = 4'd2;

        // R9: done waits for ready
        nand_rb_n = 1'b0;
        issue(8'h90, 1, 16'h0020, 0, 24'h0);
        while (ncap < 2) @(negedge clk);
        repeat (30) @(negedge clk);
        chk("R9", "no done while not ready", ndone, 0);
        chk("R9", "busy while not ready", busy, 1);
        nand_rb_n = 1'b1;
        wait_done(100);
        chk("R9", "done after ready", ndone, 1);
        chk("R9", "no error after ready", done_err, 0);

        // R10: timeout
        cfg_rdy_tmo = 16'd25;
        nand_rb_n = 1'b0;
        issue(8'h70, 0, 16'h0, 0, 24'h0);
        wait_done(500);
        chk("R10", "done on timeout", ndone, 1);
        chk("R10", "error flag", done_err, 1);
        chk("R10", "wait at least limit", (done_cyc - last_rise) >= 25, 1);
        chk("R10", "wait bounded", (done_cyc - last_rise) <= 31, 1);
        @(negedge clk);
        chk("R10", "CE# high after timeout", nand_ce_n, 1);
        nand_rb_n = 1'b1;
        cfg_rdy_tmo = 16'd1000;

        // R12: request while busy is ignored
        issue(8'h00, 1, 16'h4321, 1, 24'h123456);
        repeat (3) @(negedge clk);
        req_valid = 1'b1; req_op = 8'h70;
        @(negedge clk);
        req_valid = 1'b0;
        wait_done(3000);
        check_seq("R12", 8'h00, 1, 16'h4321, 1, 24'h123456, 2);
        repeat (20) @(negedge clk);
        chk("R12", "no extra cycles", ncap, 7);
        chk("R12", "idle afterwards", busy, 0);

        // constrained random mix
        for (int k = 0; k < 60; k++) begin
            logic [7:0] op;
            int pick;
            pick = $urandom_range(0, 17);
            op = (pick < 16) ? ops[pick] : 8'($urandom_range(0, 255));
            cfg_we_low = 4'($urandom_range(0, 4));
            full_op((op == 8'h50) ? "R5" : "R3", op, 1'($urandom_range(0, 1)),
                    16'($urandom), 1'($urandom_range(0, 1)), 24'($urandom));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule